// File: doc/BRIEF.md
# Power-of-Two Exponential Smoothing Filter

This block smooths a stream of unsigned ADC samples with a first-order recursive low-pass filter. Its coefficient is 1/2^k, so the update needs only a subtract, a shift and an add, and no multiplier. The filter keeps one accumulator that holds the running value scaled up by 2^k. Each accepted sample gives exactly one filtered result one clock later. The result stays in the same range as the input. The filter works sample by sample, with no blocks or windows.

The first sample accepted after reset, or after a synchronous clear, seeds the accumulator directly and passes through unchanged. The output therefore starts at the signal level and does not ramp up from zero. The response time constant is about 2^k samples. With k = 4 the output behaves roughly like a 16-sample moving average, and with k = 8 it needs a few hundred samples to settle after a step. Typical use is a slowly varying sensor channel (temperature, supply voltage) sitting between an ADC and a consumer that wants fewer noisy codes.

Top module: `ema_smoother`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0 and `out_data` is 0.
- R2: The first sample accepted after reset or clear loads the accumulator with the sample shifted left by k. The next cycle shows that same sample unchanged on `out_data`.
- R3: Each later accepted sample x changes the accumulator A to A − (A >> k) + x. The output is the new A >> k.
- R4: After a non-seeding accepted sample, the new output lies between the previous output and that sample, both ends included. It never leaves the input code range, even for runs of full-scale (all ones) or zero codes.
- R5: `out_valid` is high for exactly one cycle, in the cycle after each accepted sample. An accepted sample is one with `in_valid` high and `clr` low. There is one output per accepted sample.
- R6: In a cycle with `in_valid` low, `in_sample` has no effect. In the next cycle `out_valid` is low and `out_data` keeps its previous value.
- R7: `clr` is synchronous and takes priority over `in_valid`. A sample presented together with `clr` is discarded and produces no output. The next accepted sample seeds the filter again, as in R2.
- R8: With k = 4, seed the filter with 0 and then feed it full scale (4095). After 16 samples the output is above 2048 and below 4095. After 256 samples it equals 4095.
- R9: After a seed, a run of identical samples keeps the output exactly equal to that sample, with no drift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear; re-arms seeding |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | SAMPLE_W (12) | Unsigned ADC code |
| out_valid | output | 1 | Filtered result strobe |
| out_data | output | SAMPLE_W (12) | Filtered code |

## Verification
The hardest case to reach is the accumulator sitting exactly at its fixed point near full scale. Here the truncated decay term and the incoming sample cancel to the last bit, and any off-by-one in the shift width would wrap the accumulator. The bench gets there by seeding with zero and then holding 4095 for 256 samples, and afterwards alternates zero and full-scale codes. A clear presented together with a valid sample is driven on purpose, to show that the discarded sample neither produces an output nor seeds the filter. A behavioural model is compared against the outputs on every clock.

// File: rtl/ema_pkg.sv
package ema_pkg;
   localparam int unsigned EMA_MIN_K = 1;
   localparam int unsigned EMA_MAX_K = 8;
   localparam int unsigned EMA_MIN_SAMPLE_W = 2;

   function automatic int unsigned ema_acc_width(input int unsigned sample_w,
                                                 input int unsigned k);
      return sample_w + k;
   endfunction

   function automatic bit ema_params_ok(input int unsigned sample_w,
                                        input int unsigned k);
      return (k >= EMA_MIN_K) && (k <= EMA_MAX_K) && (sample_w >= EMA_MIN_SAMPLE_W);
   endfunction
endpackage

// File: rtl/ema_seed_ctrl.sv
module ema_seed_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic in_valid,
   output logic take,
   output logic seed_now
);
   logic armed_q;

   assign take     = in_valid && !clr;
   assign seed_now = take && !armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (clr) begin
         armed_q <= 1'b0;
      end else if (take) begin
         armed_q <= 1'b1;
      end
   end

   // R7: a clear always leaves the filter waiting for a new seed
   p_clear_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !armed_q);

   // R2: once seeded, a following sample without clear is not a seed
   p_single_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      seed_now |=> !(seed_now));
endmodule

// File: rtl/ema_state_reg.sv
module ema_state_reg #(
   parameter int unsigned SAMPLE_W = 12,
   parameter int unsigned SHIFT_K  = 4,
   localparam int unsigned ACC_W   = ema_pkg::ema_acc_width(SAMPLE_W, SHIFT_K)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take,
   input  logic                seed_now,
   input  logic [SAMPLE_W-1:0] sample,
   output logic [SAMPLE_W-1:0] filt_value
);
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_d;
   logic [ACC_W-1:0] decay;
   logic [ACC_W-1:0] sample_wide;
   logic [ACC_W-1:0] sample_seed;

   assign decay       = acc_q >> SHIFT_K;
   assign sample_wide = {{SHIFT_K{1'b0}}, sample};
   assign sample_seed = {sample, {SHIFT_K{1'b0}}};

   always_comb begin
      if (seed_now) begin
         acc_d = sample_seed;
      end else begin
         acc_d = acc_q - decay + sample_wide;
      end
   end

   assign filt_value = acc_d[ACC_W-1:SHIFT_K];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (take) begin
         acc_q <= acc_d;
      end
   end

   // R6: accumulator is frozen when no sample is accepted
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(acc_q));

   // R2: seeding loads the scaled sample
   p_seed_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      seed_now |=> (acc_q[ACC_W-1:SHIFT_K] == $past(sample)) &&
                   (acc_q[SHIFT_K-1:0] == '0));
endmodule

// File: rtl/ema_out_stage.sv
module ema_out_stage #(
   parameter int unsigned SAMPLE_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take,
   input  logic                seed_now,
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [SAMPLE_W-1:0] filt_value,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= take;
         if (take) begin
            out_data <= seed_now ? sample : filt_value;
         end
      end
   end

   // R5: a strobe follows every accepted sample
   p_valid_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> out_valid);

   // R6: no strobe without an accepted sample, and the data holds
   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> !out_valid && $stable(out_data));

   // R2: a seed passes straight through
   p_seed_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      seed_now |=> out_data == $past(sample));

   // R4: each update moves the output toward the new sample, never past it
   p_toward_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !seed_now) |=>
         (((out_data >= $past(out_data)) && (out_data <= $past(sample))) ||
          ((out_data <= $past(out_data)) && (out_data >= $past(sample)))));
endmodule

// File: rtl/ema_smoother.sv
module ema_smoother #(
   parameter int unsigned SAMPLE_W = 12,
   parameter int unsigned SHIFT_K  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_sample,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_data
);
   generate
      if (!ema_pkg::ema_params_ok(SAMPLE_W, SHIFT_K)) begin : g_bad_params
         $error("ema_smoother: SHIFT_K must be 1..8 and SAMPLE_W at least 2");
      end
   endgenerate

   logic                take;
   logic                seed_now;
   logic [SAMPLE_W-1:0] filt_value;

   ema_seed_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .in_valid (in_valid),
      .take     (take),
      .seed_now (seed_now)
   );

   ema_state_reg #(
      .SAMPLE_W (SAMPLE_W),
      .SHIFT_K  (SHIFT_K)
   ) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .seed_now   (seed_now),
      .sample     (in_sample),
      .filt_value (filt_value)
   );

   ema_out_stage #(
      .SAMPLE_W (SAMPLE_W)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (take),
      .seed_now   (seed_now),
      .sample     (in_sample),
      .filt_value (filt_value),
      .out_valid  (out_valid),
      .out_data   (out_data)
   );

   // R7: a sample that arrives together with clear yields no output
   p_clear_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !out_valid);
endmodule

// File: tb/ema_smoother_tb.sv
module ema_smoother_tb;
   localparam int CLK_PERIOD = 10;
   localparam int SW = 12;
   localparam int K  = 4;
   localparam int FULL = (1 << SW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr = 1'b0;
   logic          in_valid = 1'b0;
   logic [SW-1:0] in_sample = '0;
   logic          out_valid;
   logic [SW-1:0] out_data;

   int     n_checks = 0;
   int     n_fail = 0;
   int     cycles = 0;
   string  cur_req = "R1";

   longint m_acc = 0;
   bit     m_armed = 0;
   bit     e_valid = 0;
   int     e_data = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ema_smoother #(.SAMPLE_W(SW), .SHIFT_K(K)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .in_valid  (in_valid),
      .in_sample (in_sample),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 50000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run hung, actual cycles %0d expected below 50000", cycles);
         $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp_v);
      n_checks = n_checks + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
      end
   endtask

   // called at a negative edge; applies inputs, advances model, compares
   task automatic step(input bit v, input int x, input bit c);
      in_valid  = v;
      in_sample = x[SW-1:0];
      clr       = c;
      @(posedge clk);
      if (c) begin
         m_armed = 0;
         e_valid = 0;
      end else if (v) begin
         if (!m_armed) begin
            m_acc   = longint'(x) << K;
            e_data  = x;
            m_armed = 1;
         end else begin
            m_acc  = m_acc - (m_acc >> K) + longint'(x);
            e_data = int'(m_acc >> K);
         end
         e_valid = 1;
      end else begin
         e_valid = 0;
      end
      @(negedge clk);
      chk(out_valid == e_valid, {cur_req, " out_valid (R5)"}, int'(out_valid), int'(e_valid));
      chk(int'(out_data) == e_data, {cur_req, " out_data"}, int'(out_data), e_data);
   endtask

   initial begin
      int prev;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
      chk(out_data == '0, "R1 data in reset", int'(out_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0 && out_data == '0, "R1 after release", int'(out_data), 0);

      // R2: seed passes through
      cur_req = "R2";
      step(1, 1234, 0);
      chk(int'(out_data) == 1234, "R2 seed output", int'(out_data), 1234);

      // R9: constant input, no drift
      cur_req = "R9";
      for (int i = 0; i < 20; i++) begin
         step(1, 1234, 0);
         chk(int'(out_data) == 1234, "R9 constant stays", int'(out_data), 1234);
      end

      // R6: idle cycles with garbage on the data input
      cur_req = "R6";
      for (int i = 0; i < 4; i++) begin
         step(0, int'($urandom_range(0, FULL)), 0);
         chk(out_valid == 1'b0 && int'(out_data) == 1234, "R6 hold while idle",
             int'(out_data), 1234);
      end

      // R3: noisy stream with random gaps
      cur_req = "R3";
      for (int i = 0; i < 80; i++) begin
         step(($urandom_range(0, 3) != 0),
              2000 + int'($urandom_range(0, 60)) - 30, 0);
      end

      // R7: clear alone, then reseed
      cur_req = "R7";
      step(0, 0, 1);
      step(1, 100, 0);
      chk(int'(out_data) == 100 && out_valid, "R7 reseed after clear", int'(out_data), 100);
      // R7: clear together with a sample discards it
      step(1, 3000, 1);
      chk(out_valid == 1'b0 && int'(out_data) == 100, "R7 sample with clear discarded",
          int'(out_data), 100);
      step(1, 50, 0);
      chk(int'(out_data) == 50, "R7 next sample seeds", int'(out_data), 50);

      // R8: step response from 0 to full scale
      cur_req = "R8";
      step(0, 0, 1);
      step(1, 0, 0);
      for (int i = 1; i <= 256; i++) begin
         step(1, FULL, 0);
         if (i == 16) begin
            chk(int'(out_data) > 2048 && int'(out_data) < FULL, "R8 after 16 samples",
                int'(out_data), 3000);
         end
      end
      chk(int'(out_data) == FULL, "R8 settled after 256", int'(out_data), FULL);

      // R4: alternating extremes stay in range and move toward each sample
      cur_req = "R4";
      for (int i = 0; i < 40; i++) begin
         int x;
         prev = int'(out_data);
         x = (i % 2 == 0) ? 0 : FULL;
         step(1, x, 0);
         chk((int'(out_data) <= prev && int'(out_data) >= x) ||
             (int'(out_data) >= prev && int'(out_data) <= x),
             "R4 between previous output and sample", int'(out_data), x);
      end

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule